// File: doc/BRIEF.md
# Recurrent LSTM Channel Equalizer

This block recovers channel samples one symbol period at a time with a small recurrent neural network in signed Q4.12 fixed point. Each accepted sample is pushed into a tap line that holds the most recent samples. One shared multiply-accumulate unit then works through every hidden unit. For each unit it evaluates four gate pre-activations, each from the tap line, the previous hidden vector and a bias. Forget, input and output gates pass through a piecewise-linear sigmoid. The candidate passes through a tanh built from that sigmoid.

Once every unit has its gate values, cell and hidden state are updated for all units together. A single output neuron then maps the new hidden vector through a sigmoid to the equalized value. All coefficients come from a fixed, read-only parameter table.

The sample input is a valid/ready stream. A sample transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the engine is idle and `clear` is low. A producer that holds `in_valid` through a busy period has its sample taken when `in_ready` returns. In every cycle where `in_valid` is high and `in_ready` is low, the offered value is not captured and the overrun flag is set. The output has no back-pressure: `out_valid` is a one-cycle strobe, and `out_value` holds its value until the next strobe.

Top module: `lstm_equalizer`

## Requirements
- R1: After reset or a synchronous `clear`, the taps and the cell and hidden state are zero, and `in_ready` = 1 (unless `clear` is high), `out_valid` = 0 and `overrun` = 0. After reset, `out_value` = 0; `clear` leaves `out_value` unchanged.
- R2: An accepted sample enters tap 0. Tap k moves to tap k+1, and the sample in the oldest tap (index TAPS-1) is discarded. Tap k is the input of weight index k.
- R3: A sample is accepted only on an edge where `in_valid` and `in_ready` are both high. `in_ready` is low from that edge until the cycle in which `out_valid` is high.
- R4: If `in_valid` is high while `in_ready` is low, the sample is not captured and has no effect on any later output, and `overrun` becomes 1. `overrun` stays 1 until reset or `clear`.
- R5: The pre-activation for unit u and gate g is computed as follows. Sum (bias << 12), the TAPS tap products and the HIDDEN products with the previous hidden vector at full precision. Shift the sum right arithmetically by 12 and saturate it to [-32768, 32767]. Gate codes are 0 forget, 1 input, 2 candidate, 3 output.
- R6: sigmoid(x) for Q4.12 x, with a = |x| in LSBs: 2048 + a/4 if a < 4096; 2560 + a/8 if a < 9728; 3456 + a/32 if a < 20480; otherwise 4096. Each division truncates. For negative x the result is 4096 minus this value.
- R7: tanh(x) = 2·sigmoid(2x) − 4096, where 2x is taken without saturation.
- R8: c_new = sat((f·c + i·cand) >>> 12) and h_new = sat((o·tanh(c_new)) >>> 12), computed per unit. Every unit uses the hidden vector from the previous sample, and all units commit together.
- R9: The output is sigmoid(sat((b_out << 12 + Σ w_out[j]·h_new[j]) >>> 12)) and always lies in [0, 4096].
- R10: The coefficient with index n has the value (((53n + 17) mod 101) − 50)·40. Let row = TAPS + HIDDEN + 1. Gate (u, g) uses indices (4u + g)·row + k, with k < TAPS for taps, then TAPS + j for h[j], then TAPS + HIDDEN for its bias. The output neuron uses 4·HIDDEN·row + j for h[j] and 4·HIDDEN·row + HIDDEN for its bias.
- R11: `out_valid` is high for exactly one cycle, 4·HIDDEN·(TAPS+HIDDEN) + HIDDEN + 1 clock edges after the accepting edge. `out_value` changes only when `out_valid` is high.
- R12: A `clear` during a computation abandons it: no `out_valid` follows for that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of taps, state and overrun; aborts work in progress |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Engine idle and able to take a sample |
| in_sample | input | 16 | Signed Q4.12 channel sample |
| out_valid | output | 1 | One-cycle strobe: new equalized value |
| out_value | output | 16 | Signed Q4.12 equalized value, held between strobes |
| overrun | output | 1 | Sticky: a sample was offered while busy |

## Verification
The properties assume that `clear` is a clean synchronous level and that reset is applied once before traffic. They place no limit on sample values, and no limit on when `in_valid` rises or how long it is held. The stimulus therefore covers the ranges and timings those properties allow. It uses full-scale and saturating samples and pseudo-random samples. It offers samples back to back in the very cycle `in_ready` returns, holds `in_valid` through whole busy periods, sends single-cycle offers into a busy engine, and asserts `clear` mid-computation.

// File: rtl/lstm_eq_pkg.sv
package lstm_eq_pkg;
  localparam int QW   = 16;
  localparam int FRAC = 12;
  localparam int AW   = 48;

  typedef logic signed [QW-1:0] q_t;
  typedef logic signed [AW-1:0] acc_t;

  typedef enum logic [1:0] {ST_IDLE, ST_GATE, ST_COMMIT, ST_OUT} state_e;

  localparam logic [1:0] GATE_FORGET = 2'd0;
  localparam logic [1:0] GATE_INPUT  = 2'd1;
  localparam logic [1:0] GATE_CAND   = 2'd2;
  localparam logic [1:0] GATE_OUT    = 2'd3;

  // Drop the fraction of a full-precision sum and clamp to Q4.12.
  function automatic q_t sat_q(input acc_t a);
    acc_t s;
    s = a >>> FRAC;
    if (s > acc_t'(32767)) return 16'sh7fff;
    else if (s < acc_t'(-32768)) return 16'sh8000;
    else return q_t'(s[QW-1:0]);
  endfunction

  // Eight-segment odd-symmetric sigmoid approximation on an 18-bit input.
  function automatic q_t pwl_sigmoid(input logic signed [QW+1:0] x);
    int xi;
    int a;
    int y;
    xi = int'(x);
    a  = (xi < 0) ? -xi : xi;
    if (a < 4096)       y = 2048 + (a >> 2);
    else if (a < 9728)  y = 2560 + (a >> 3);
    else if (a < 20480) y = 3456 + (a >> 5);
    else                y = 4096;
    if (xi < 0) y = 4096 - y;
    return q_t'(y);
  endfunction

  function automatic q_t pwl_tanh(input q_t x);
    logic signed [QW+1:0] x2;
    q_t s;
    x2 = {x[QW-1], x, 1'b0};
    s  = pwl_sigmoid(x2);
    return q_t'(2 * int'(s) - 4096);
  endfunction
endpackage

// File: rtl/lstm_act.sv
module lstm_act
  import lstm_eq_pkg::*;
#(
  parameter bit USE_TANH = 1'b0
) (
  input  q_t x,
  output q_t y
);
  generate
    if (USE_TANH) begin : g_tanh
      assign y = pwl_tanh(x);
    end else begin : g_sig
      assign y = pwl_sigmoid({{2{x[QW-1]}}, x});
    end
  endgenerate
endmodule

// File: rtl/lstm_param_rom.sv
module lstm_param_rom
  import lstm_eq_pkg::*;
#(
  parameter int HIDDEN = 4,
  parameter int TAPS   = 4,
  parameter int UW     = 2,
  parameter int TW     = 3
) (
  input  logic          out_sel,
  input  logic [UW-1:0] unit_idx,
  input  logic [1:0]    gate_idx,
  input  logic [TW-1:0] term_idx,
  output q_t            weight,
  output q_t            bias
);
  localparam int ROW      = TAPS + HIDDEN + 1;
  localparam int OUT_BASE = 4 * HIDDEN * ROW;

  function automatic q_t coeff(input int idx);
    return q_t'((((idx * 53 + 17) % 101) - 50) * 40);
  endfunction

  int row_base;

  always_comb begin
    if (out_sel) row_base = OUT_BASE;
    else         row_base = (int'(unit_idx) * 4 + int'(gate_idx)) * ROW;
    weight = coeff(row_base + int'(term_idx));
    bias   = coeff(row_base + (out_sel ? HIDDEN : TAPS + HIDDEN));
  end
endmodule

// File: rtl/lstm_cell_upd.sv
module lstm_cell_upd
  import lstm_eq_pkg::*;
(
  input  q_t f_g,
  input  q_t i_g,
  input  q_t cand,
  input  q_t o_g,
  input  q_t c_prev,
  output q_t c_next,
  output q_t h_next
);
  logic signed [2*QW-1:0] p_keep, p_new, p_out;
  q_t c_tanh;

  assign p_keep = f_g * c_prev;
  assign p_new  = i_g * cand;
  assign c_next = sat_q(acc_t'(p_keep) + acc_t'(p_new));

  lstm_act #(.USE_TANH(1'b1)) u_tanh (.x(c_next), .y(c_tanh));

  assign p_out  = o_g * c_tanh;
  assign h_next = sat_q(acc_t'(p_out));
endmodule

// File: rtl/lstm_equalizer.sv
module lstm_equalizer
  import lstm_eq_pkg::*;
#(
  parameter int HIDDEN = 4,
  parameter int TAPS   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_sample,
  output logic        out_valid,
  output logic [15:0] out_value,
  output logic        overrun
);
  localparam int TERMS = TAPS + HIDDEN;
  localparam int UW    = (HIDDEN > 1) ? $clog2(HIDDEN) : 1;
  localparam int TW    = $clog2(TERMS + 1);

  state_e        state_q;
  logic [UW-1:0] unit_q;
  logic [1:0]    gsel_q;
  logic [TW-1:0] term_q;
  acc_t          acc_q;
  q_t            y_q;
  logic          vld_q, ov_q;

  q_t taps_q [TAPS];
  q_t c_q    [HIDDEN];
  q_t h_q    [HIDDEN];
  q_t scr_q  [HIDDEN][4];
  q_t c_new  [HIDDEN];
  q_t h_new  [HIDDEN];

  q_t   opnd, weight, bias, pre, act_sig, act_tanh, gres;
  logic signed [2*QW-1:0] prod;
  acc_t acc_base, acc_nxt;
  logic gate_last, out_last, unit_last;

  assign in_ready  = (state_q == ST_IDLE) && !clear;
  assign out_valid = vld_q;
  assign out_value = y_q;
  assign overrun   = ov_q;

  // Operand select: taps then old hidden vector for gates, hidden vector for output.
  always_comb begin
    opnd = '0;
    for (int k = 0; k < TAPS; k++)
      if (state_q == ST_GATE && int'(term_q) == k) opnd = taps_q[k];
    for (int j = 0; j < HIDDEN; j++)
      if ((state_q == ST_GATE && int'(term_q) == TAPS + j) ||
          (state_q == ST_OUT && int'(term_q) == j)) opnd = h_q[j];
  end

  lstm_param_rom #(.HIDDEN(HIDDEN), .TAPS(TAPS), .UW(UW), .TW(TW)) u_rom (
    .out_sel (state_q == ST_OUT),
    .unit_idx(unit_q),
    .gate_idx(gsel_q),
    .term_idx(term_q),
    .weight  (weight),
    .bias    (bias)
  );

  assign prod     = weight * opnd;
  assign acc_base = (term_q == '0) ? (acc_t'(bias) <<< FRAC) : acc_q;
  assign acc_nxt  = acc_base + acc_t'(prod);
  assign pre      = sat_q(acc_nxt);

  lstm_act #(.USE_TANH(1'b0)) u_sig  (.x(pre), .y(act_sig));
  lstm_act #(.USE_TANH(1'b1)) u_tanh (.x(pre), .y(act_tanh));

  assign gres      = (gsel_q == GATE_CAND) ? act_tanh : act_sig;
  assign gate_last = int'(term_q) == TERMS - 1;
  assign out_last  = int'(term_q) == HIDDEN - 1;
  assign unit_last = int'(unit_q) == HIDDEN - 1;

  generate
    for (genvar u = 0; u < HIDDEN; u++) begin : g_unit
      lstm_cell_upd u_upd (
        .f_g   (scr_q[u][GATE_FORGET]),
        .i_g   (scr_q[u][GATE_INPUT]),
        .cand  (scr_q[u][GATE_CAND]),
        .o_g   (scr_q[u][GATE_OUT]),
        .c_prev(c_q[u]),
        .c_next(c_new[u]),
        .h_next(h_new[u])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      unit_q  <= '0;
      gsel_q  <= '0;
      term_q  <= '0;
      acc_q   <= '0;
      y_q     <= '0;
      vld_q   <= 1'b0;
      ov_q    <= 1'b0;
      for (int k = 0; k < TAPS; k++) taps_q[k] <= '0;
      for (int u = 0; u < HIDDEN; u++) begin
        c_q[u] <= '0;
        h_q[u] <= '0;
        for (int g = 0; g < 4; g++) scr_q[u][g] <= '0;
      end
    end else if (clear) begin
      state_q <= ST_IDLE;
      unit_q  <= '0;
      gsel_q  <= '0;
      term_q  <= '0;
      vld_q   <= 1'b0;
      ov_q    <= 1'b0;
      for (int k = 0; k < TAPS; k++) taps_q[k] <= '0;
      for (int u = 0; u < HIDDEN; u++) begin
        c_q[u] <= '0;
        h_q[u] <= '0;
      end
    end else begin
      vld_q <= 1'b0;
      if (in_valid && !in_ready) ov_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (in_valid) begin
          taps_q[0] <= q_t'(in_sample);
          for (int k = 1; k < TAPS; k++) taps_q[k] <= taps_q[k-1];
          unit_q  <= '0;
          gsel_q  <= GATE_FORGET;
          term_q  <= '0;
          state_q <= ST_GATE;
        end
        ST_GATE: begin
          acc_q <= acc_nxt;
          if (gate_last) begin
            for (int u = 0; u < HIDDEN; u++)
              for (int g = 0; g < 4; g++)
                if (int'(unit_q) == u && int'(gsel_q) == g) scr_q[u][g] <= gres;
            term_q <= '0;
            if (gsel_q == GATE_OUT) begin
              gsel_q <= GATE_FORGET;
              if (unit_last) state_q <= ST_COMMIT;
              else           unit_q  <= unit_q + 1'b1;
            end else begin
              gsel_q <= gsel_q + 2'd1;
            end
          end else begin
            term_q <= term_q + 1'b1;
          end
        end
        ST_COMMIT: begin
          for (int u = 0; u < HIDDEN; u++) begin
            c_q[u] <= c_new[u];
            h_q[u] <= h_new[u];
          end
          term_q  <= '0;
          state_q <= ST_OUT;
        end
        ST_OUT: begin
          acc_q <= acc_nxt;
          if (out_last) begin
            y_q     <= act_sig;
            vld_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            term_q <= term_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lstm_equalizer_chk.sv
module lstm_equalizer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clear,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic [15:0] out_value,
  input logic        overrun
);
  assert_clear_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!out_valid && !overrun));

  assert_clear_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !out_valid) |=> (!overrun && !out_valid));

  assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_overrun_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !clear) |=> overrun);

  assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clear) |=> overrun);

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_value_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |=> (out_valid || $stable(out_value)));

  assert_ready_with_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_ready || clear));

  assert_output_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_value) >= 0 && $signed(out_value) <= 16'sd4096));
endmodule

bind lstm_equalizer lstm_equalizer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clear    (clear),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_value(out_value),
  .overrun  (overrun)
);

// File: tb/lstm_equalizer_tb.sv
module lstm_equalizer_tb;
  localparam int HID = 4;
  localparam int TAPS = 4;
  localparam int ROW = TAPS + HID + 1;
  localparam int OBASE = 4 * HID * ROW;
  localparam int LAT = 4 * HID * (TAPS + HID) + HID + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic in_ready, out_valid, overrun;
  logic [15:0] out_value;

  always #5 clk = ~clk;

  lstm_equalizer #(.HIDDEN(HID), .TAPS(TAPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
    .in_ready(in_ready), .in_sample(in_sample), .out_valid(out_valid),
    .out_value(out_value), .overrun(overrun)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Behavioural model state
  longint m_taps[TAPS];
  longint m_c[HID];
  longint m_h[HID];
  int busy = 0;
  longint pend = 0;
  longint hold = 0;
  bit exp_ov = 1'b0;
  bit exp_vld = 1'b0;
  logic [15:0] lfsr = 16'hace1;

  function automatic longint mcoef(int n);
    return longint'((((n * 53 + 17) % 101) - 50) * 40);
  endfunction

  function automatic longint msat(longint a);
    longint s;
    s = a >>> 12;
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return s;
  endfunction

  function automatic longint msig(longint x);
    longint a, y;
    a = (x < 0) ? -x : x;
    if (a < 4096) y = 2048 + a / 4;
    else if (a < 9728) y = 2560 + a / 8;
    else if (a < 20480) y = 3456 + a / 32;
    else y = 4096;
    return (x < 0) ? 4096 - y : y;
  endfunction

  function automatic longint mtanh(longint x);
    return 2 * msig(2 * x) - 4096;
  endfunction

  function automatic longint forward(longint s);
    longint g[HID][4];
    longint hn[HID];
    longint acc, pre;
    for (int k = TAPS - 1; k > 0; k--) m_taps[k] = m_taps[k-1];
    m_taps[0] = s;
    for (int u = 0; u < HID; u++)
      for (int gi = 0; gi < 4; gi++) begin
        int base = (4 * u + gi) * ROW;
        acc = mcoef(base + TAPS + HID) * 4096;
        for (int k = 0; k < TAPS; k++) acc += mcoef(base + k) * m_taps[k];
        for (int j = 0; j < HID; j++) acc += mcoef(base + TAPS + j) * m_h[j];
        pre = msat(acc);
        g[u][gi] = (gi == 2) ? mtanh(pre) : msig(pre);
      end
    for (int u = 0; u < HID; u++) begin
      m_c[u] = msat(g[u][0] * m_c[u] + g[u][1] * g[u][2]);
      hn[u] = msat(g[u][3] * mtanh(m_c[u]));
    end
    for (int u = 0; u < HID; u++) m_h[u] = hn[u];
    acc = mcoef(OBASE + HID) * 4096;
    for (int j = 0; j < HID; j++) acc += mcoef(OBASE + j) * m_h[j];
    return msig(msat(acc));
  endfunction

  task automatic model_clear();
    for (int k = 0; k < TAPS; k++) m_taps[k] = 0;
    for (int u = 0; u < HID; u++) begin m_c[u] = 0; m_h[u] = 0; end
    busy = 0;
    exp_ov = 1'b0;
  endtask

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // One clock period, starting and ending at a falling edge.
  task automatic tick(bit v, longint s, bit clr);
    in_valid = v;
    in_sample = 16'(s);
    clear = clr;
    #1;
    check("R3", "in_ready", in_ready, (busy == 0 && !clr));
    if (clr) model_clear();
    else if (v && busy == 0) begin pend = forward(s); busy = LAT + 1; end
    else if (v) exp_ov = 1'b1;  // R4: offered while busy, not captured
    @(negedge clk);
    exp_vld = 1'b0;
    if (busy > 0) begin
      busy--;
      if (busy == 0) begin exp_vld = 1'b1; hold = pend; end
    end
    check("R11", "out_valid", out_valid, exp_vld);
    check("R2/R5/R6/R7/R8/R9/R10", "out_value", longint'($signed(out_value)), hold);
    check("R4", "overrun", overrun, exp_ov);
  endtask

  task automatic idle_to_ready();
    while (busy != 0) tick(1'b0, 0, 1'b0);
  endtask

  task automatic feed(longint s);
    idle_to_ready();
    tick(1'b1, s, 1'b0);
  endtask

  task automatic hold_feed(longint s);
    bit taken;
    do begin
      taken = (busy == 0);
      tick(1'b1, s, 1'b0);
    end while (!taken);
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "in_ready", in_ready, 1);
    check("R1", "out_valid", out_valid, 0);
    check("R1", "overrun", overrun, 0);
    check("R1", "out_value", out_value, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: impulse walks through the taps
    feed(4096);
    for (int i = 0; i < 4; i++) feed(0);
    // alternating full-scale
    for (int i = 0; i < 6; i++) feed((i % 2) ? -4096 : 4096);
    // saturating extremes (R5 clamp)
    for (int i = 0; i < 4; i++) feed((i % 2) ? -32768 : 32767);
    // pseudo-random, offered in the same cycle ready returns
    for (int i = 0; i < 16; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      feed(longint'($signed(lfsr)));
    end

    // R4: single-cycle offer into a busy engine is dropped
    feed(1000);
    repeat (5) tick(1'b0, 0, 1'b0);
    tick(1'b1, 7777, 1'b0);
    check("R4", "overrun set", overrun, 1);
    feed(-1500);
    feed(2500);
    // held valid through busy periods
    hold_feed(-3000);
    hold_feed(12000);
    check("R4", "overrun sticky", overrun, 1);

    // R12: clear mid-computation abandons the result
    feed(2000);
    repeat (10) tick(1'b0, 0, 1'b0);
    tick(1'b0, 0, 1'b1);
    check("R1", "overrun cleared", overrun, 0);
    for (int i = 0; i < LAT + 20; i++) tick(1'b0, 0, 1'b0);
    check("R12", "no late out_valid", out_valid, 0);
    // from zero state again (R1)
    feed(4096);
    feed(-2048);
    feed(300);
    idle_to_ready();
    repeat (3) tick(1'b0, 0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule